// File: doc/BRIEF.md
# Multicast Hash Destination Filter

This block sits in a receive path and decides whether an incoming Ethernet frame should be kept or dropped, based only on the frame's 48-bit destination address. The address arrives as a byte stream, one octet per clock. A start-of-frame strobe, which carries no data, comes first. While the six address octets stream in, the block collects them and runs the Ethernet CRC-32 over them. Once the sixth octet has been taken, the block classifies the address as unicast, multicast or broadcast. It then produces one registered accept/discard decision.

Unicast addresses are compared with a programmed station address. The all-ones broadcast address passes only when broadcast reception is enabled. Other multicast addresses are filtered through a 64-bit hash table. Software writes this table as eight byte-wide entries. Six bits of the address CRC pick one bit of the table, and that bit decides. A promiscuous control overrides every other rule. The decision stays on the output until the next start of frame. Payload octets that follow the address have no effect on it.

Top module: `mcast_dest_filter`

## Requirements
- R1: After reset every hash table entry is zero, so a multicast frame is discarded even with multicast reception enabled, and `decision_valid` is 0.
- R2: The CRC register is preset to all ones at start of frame. It is updated once per address octet, bit 0 first, with the reflected polynomial 0xEDB88320, and is not inverted at the end. Bits [30:25] of the result form the hash key. Key bits [5:3] select table entry 0..7 and key bits [2:0] select a bit within that entry. With `mcast_en`=1, a multicast frame is accepted exactly when that bit is 1.
- R3: With `mcast_en`=0, every multicast frame that is not broadcast is discarded, whatever the table holds.
- R4: The all-ones destination address is classified as broadcast, not multicast. It is accepted exactly when `bcast_en`=1, whatever the table and `mcast_en` hold.
- R5: An address whose first octet has bit 0 clear is unicast. It is accepted exactly when it equals `station_addr`, where the first octet on the wire is `station_addr[47:40]` and the sixth is `station_addr[7:0]`.
- R6: With `promisc_en`=1, every frame is accepted, whatever its address type and the table contents.
- R7: `decision_valid` is 0 in the cycle after the sixth octet's clock edge and rises on the edge after that. From then on, `decision_valid` and `accept` hold steady through any further octets until `frm_start` clears `decision_valid` at the next clock edge.
- R8: A table write stores `tbl_wr_data` in the entry picked by `tbl_wr_sel` on the clock edge. A later write to the same entry replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Start-of-frame strobe, carries no octet |
| oct_valid | input | 1 | `oct_data` holds a received octet |
| oct_data | input | 8 | Received octet |
| station_addr | input | 48 | Own unicast address, first wire octet in [47:40] |
| mcast_en | input | 1 | Multicast reception enable |
| bcast_en | input | 1 | Broadcast reception enable |
| promisc_en | input | 1 | Accept every frame |
| tbl_wr_en | input | 1 | Hash table write strobe |
| tbl_wr_sel | input | 3 | Hash table entry to write |
| tbl_wr_data | input | 8 | Hash table write value |
| decision_valid | output | 1 | Decision for the current frame is available |
| accept | output | 1 | 1 = keep frame, 0 = discard |

## Verification
The hardest case is landing on a chosen hash bit, because the table bit that a multicast address selects is hidden behind a CRC. The bench therefore carries its own bitwise CRC model and derives the key for each address. It programs the matching bit in its table model and in the design, and then sends that address. It also sends addresses whose keys land on cleared bits, and rewrites entries so that a bit that was set becomes clear.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    localparam int OCT_W      = 8;
    localparam int ADDR_OCTS  = 6;
    localparam int ADDR_W     = OCT_W * ADDR_OCTS;
    localparam int TBL_NUM    = 8;
    localparam int TBL_SEL_W  = $clog2(TBL_NUM);
    localparam int BIT_SEL_W  = $clog2(OCT_W);
    localparam int CNT_W      = $clog2(ADDR_OCTS + 1);
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [1:0] {
        DST_UNI   = 2'd0,
        DST_MULTI = 2'd1,
        DST_BCAST = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic [TBL_SEL_W-1:0] sel;
        logic [BIT_SEL_W-1:0] bit_idx;
    } hash_key_t;

    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [OCT_W-1:0] octet);
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < OCT_W; i++) begin
            if (c[0] ^ octet[i]) c = (c >> 1) ^ CRC_POLY;
            else                 c = c >> 1;
        end
        return c;
    endfunction

    function automatic hash_key_t key_of(input logic [31:0] crc);
        hash_key_t k;
        k.sel     = crc[30:28];
        k.bit_idx = crc[27:25];
        return k;
    endfunction
endpackage

// File: rtl/mdf_crc.sv
module mdf_crc
    import mdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step_en,
    input  logic [OCT_W-1:0] octet,
    output logic [31:0]      crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clear)  crc_q <= '1;
        else if (step_en)  crc_q <= crc_step(crc_q, octet);
    end

    p_preset_r2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc_q == 32'hFFFF_FFFF));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!clear && !step_en) |=> $stable(crc_q));
endmodule

// File: rtl/mdf_addr_capture.sv
module mdf_addr_capture
    import mdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              oct_valid,
    input  logic [OCT_W-1:0]  oct_data,
    output logic              take,
    output logic              addr_full,
    output logic [ADDR_W-1:0] addr_q,
    output dst_class_e        dst_class
);
    logic [CNT_W-1:0] cnt_q;

    assign addr_full = (cnt_q == CNT_W'(ADDR_OCTS));
    assign take      = oct_valid && !addr_full && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= {addr_q[ADDR_W-OCT_W-1:0], oct_data};
        end
    end

    always_comb begin
        if (&addr_q)                       dst_class = DST_BCAST;
        else if (addr_q[ADDR_W-OCT_W])     dst_class = DST_MULTI;
        else                               dst_class = DST_UNI;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ADDR_OCTS));
    p_full_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (addr_full && !clear) |=> $stable(addr_q));
endmodule

// File: rtl/mdf_hash_table.sv
module mdf_hash_table
    import mdf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [TBL_SEL_W-1:0] wr_sel,
    input  logic [OCT_W-1:0]     wr_data,
    input  hash_key_t            key,
    output logic                 hit
);
    logic [TBL_NUM-1:0][OCT_W-1:0] tbl_q;

    for (genvar g = 0; g < TBL_NUM; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)                                       tbl_q[g] <= '0;
            else if (wr_en && wr_sel == TBL_SEL_W'(g))     tbl_q[g] <= wr_data;
        end
    end

    assign hit = tbl_q[key.sel][key.bit_idx];

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (tbl_q == '0));
    p_no_write_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tbl_q));
endmodule

// File: rtl/mcast_dest_filter.sv
module mcast_dest_filter
    import mdf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frm_start,
    input  logic         oct_valid,
    input  logic [7:0]   oct_data,
    input  logic [47:0]  station_addr,
    input  logic         mcast_en,
    input  logic         bcast_en,
    input  logic         promisc_en,
    input  logic         tbl_wr_en,
    input  logic [2:0]   tbl_wr_sel,
    input  logic [7:0]   tbl_wr_data,
    output logic         decision_valid,
    output logic         accept
);
    logic              take, addr_full, hash_hit, verdict;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       crc_q;
    dst_class_e        dst_class;

    mdf_addr_capture u_cap (
        .clk(clk), .rst(rst), .clear(frm_start),
        .oct_valid(oct_valid), .oct_data(oct_data),
        .take(take), .addr_full(addr_full), .addr_q(addr_q),
        .dst_class(dst_class)
    );

    mdf_crc u_crc (
        .clk(clk), .rst(rst), .clear(frm_start),
        .step_en(take), .octet(oct_data), .crc_q(crc_q)
    );

    mdf_hash_table u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel), .wr_data(tbl_wr_data),
        .key(key_of(crc_q)), .hit(hash_hit)
    );

    always_comb begin
        if (promisc_en) verdict = 1'b1;
        else begin
            unique case (dst_class)
                DST_BCAST: verdict = bcast_en;
                DST_MULTI: verdict = mcast_en && hash_hit;
                default:   verdict = (addr_q == station_addr);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frm_start) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
        end else if (addr_full && !decision_valid) begin
            decision_valid <= 1'b1;
            accept         <= verdict;
        end
    end

    p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> !decision_valid);
    p_held_r7: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && !frm_start) |=> (decision_valid && $stable(accept)));
    p_promisc_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(decision_valid) && $past(promisc_en)) |-> accept);
    p_mcast_off_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(decision_valid) && $past(dst_class == DST_MULTI)
         && $past(!promisc_en && !mcast_en)) |-> !accept);
    p_bcast_off_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(decision_valid) && $past(dst_class == DST_BCAST)
         && $past(!promisc_en && !bcast_en)) |-> !accept);
endmodule

// File: tb/sim_mcast_dest_filter.sv
module sim_mcast_dest_filter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_start = 0, oct_valid = 0;
    logic [7:0] oct_data = '0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic mcast_en = 0, bcast_en = 0, promisc_en = 0;
    logic tbl_wr_en = 0;
    logic [2:0] tbl_wr_sel = '0;
    logic [7:0] tbl_wr_data = '0;
    logic decision_valid, accept;

    int n_chk = 0, n_bad = 0;
    bit exp_q[$];
    string tag_q[$];
    logic [7:0] tbl_m [8];

    always #5 clk = ~clk;

    mcast_dest_filter u0 (.*);

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int o = 0; o < 6; o++) begin
            logic [7:0] d = a[47 - 8*o -: 8];
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ d[b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    function automatic logic [5:0] model_key(input logic [47:0] a);
        logic [31:0] c = model_crc(a);
        return c[30:25];
    endfunction

    function automatic bit model_accept(input logic [47:0] a);
        logic [5:0] k;
        if (promisc_en) return 1;
        if (a == 48'hFFFF_FFFF_FFFF) return bcast_en;
        if (a[40]) begin
            k = model_key(a);
            return mcast_en && tbl_m[k[5:3]][k[2:0]];
        end
        return a == station_addr;
    endfunction

    task automatic tbl_write(input int sel, input logic [7:0] v);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_sel = 3'(sel); tbl_wr_data = v;
        @(negedge clk);
        tbl_wr_en = 0;
        tbl_m[sel] = v;
    endtask

    task automatic set_key_bit(input logic [47:0] a, input logic v);
        logic [5:0] k = model_key(a);
        logic [7:0] e = tbl_m[k[5:3]];
        e[k[2:0]] = v;
        tbl_write(int'(k[5:3]), e);
    endtask

    // driver: pushes the expected decision, sends the frame, checks R7 timing
    task automatic send(input string req, input logic [47:0] a);
        exp_q.push_back(model_accept(a));
        tag_q.push_back(req);
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0;
        check("R7 cleared by start", decision_valid, 1'b0);
        for (int o = 0; o < 6; o++) begin
            oct_valid = 1; oct_data = a[47 - 8*o -: 8];
            @(negedge clk);
        end
        oct_valid = 0;
        check("R7 not early", decision_valid, 1'b0);
        @(negedge clk);
        check("R7 valid after sixth", decision_valid, 1'b1);
    endtask

    // monitor: pops on each new decision
    initial begin
        logic prev = 0;
        forever begin
            @(negedge clk);
            #1;
            if (decision_valid && !prev) begin
                if (exp_q.size() == 0) check("R7 unexpected decision", 1'b1, 1'b0);
                else check(tag_q.pop_front(), accept, exp_q.pop_front());
            end
            prev = decision_valid;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] m1 = 48'h01_00_5E_00_00_01;
        logic [47:0] m2 = 48'h33_33_00_00_00_FB;
        logic [47:0] m3 = 48'h01_80_C2_00_00_0E;
        logic [47:0] bc = 48'hFFFF_FFFF_FFFF;
        logic acc_hold;
        for (int i = 0; i < 8; i++) tbl_m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 valid low after reset", decision_valid, 1'b0);

        mcast_en = 1;
        send("R1 mcast rejected by empty table", m1);

        set_key_bit(m1, 1);
        send("R2 mcast hash bit set", m1);
        if (model_key(m2) != model_key(m1)) send("R2 mcast hash bit clear", m2);
        set_key_bit(m2, 1);
        send("R2 second key set", m2);
        set_key_bit(m1, 0);
        send("R8 rewrite clears bit", m1);
        send("R2 other table untouched", m3);
        for (int i = 0; i < 8; i++) tbl_write(i, 8'hFF);
        send("R2 full table accepts", m3);

        mcast_en = 0;
        send("R3 mcast disabled", m3);
        send("R3 mcast disabled m2", m2);

        bcast_en = 0; mcast_en = 1;
        send("R4 bcast disabled ignores table", bc);
        bcast_en = 1; mcast_en = 0;
        send("R4 bcast enabled", bc);
        for (int i = 0; i < 8; i++) tbl_write(i, 8'h00);
        bcast_en = 1; mcast_en = 1;
        send("R4 bcast ignores empty table", bc);

        send("R5 unicast match", station_addr);
        send("R5 unicast mismatch", 48'h02_11_22_33_44_56);
        send("R5 unicast first octet differs", 48'h04_11_22_33_44_55);

        bcast_en = 0; mcast_en = 0; promisc_en = 1;
        send("R6 promisc unicast", 48'h00_AA_BB_CC_DD_EE);
        send("R6 promisc mcast", m1);
        send("R6 promisc bcast", bc);
        promisc_en = 0;

        // R7 hold: extra octets after the address must not disturb the decision
        send("R5 match before payload", station_addr);
        @(negedge clk);
        acc_hold = accept;
        for (int o = 0; o < 5; o++) begin
            oct_valid = 1; oct_data = 8'(8'hA5 + o);
            @(negedge clk);
        end
        oct_valid = 0;
        check("R7 valid held over payload", decision_valid, 1'b1);
        check("R7 accept held over payload", accept, acc_hold);

        repeat (4) @(negedge clk);
        check("R7 queue drained", 1'(exp_q.size() == 0), 1'b1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule